// File: doc/BRIEF.md
# Instruction Prefetch Queue with Early Jump Redirect

This block separates instruction fetch from instruction dispatch. The fetch side holds a program counter and sends sequential word addresses to an instruction memory. That memory can take a variable number of cycles to answer, but it answers in request order. Each returned word goes into a small in-order queue. The dispatch side reads the oldest entry and hands it on when the later stages accept it and are not stalled. Each side therefore keeps working while the other one waits. A downstream stall lets the queue fill. A slow memory lets the queue drain.

Each returned word is decoded in the fetch side. If it is an unconditional jump, its target is computed there at once, and the next request goes to that target one cycle later. The jump itself still enters the queue and is dispatched in program order. Every request carries an epoch tag, and the memory echoes that tag with the data. Sequential words that were already requested behind a taken jump come back with an old tag and are thrown away. Requests are issued only when the queue is certain to have space for their data. The memory response therefore has no back-pressure: a response is accepted in the cycle it is presented. The request channel is valid/ready, and the address may change while it waits only because of a redirect. The dispatch channel is valid/ready, qualified by a separate stall input.

Top module: `prefetch_dispatch_queue`

## Requirements
- R1: While reset is asserted and after it, the queue is empty, `disp_valid` is low and `mem_req_addr` equals the parameter `RESET_PC`.
- R2: When no jump is taken, each accepted request (`mem_req_valid` and `mem_req_ready`) is followed by a request at the address plus 4.
- R3: `mem_req_valid` is high exactly when the queue entries plus the requests still awaiting a response total fewer than `DEPTH`.
- R4: `disp_valid` is high exactly when the queue holds an entry, and entries leave in the order their responses arrived.
- R5: An entry is removed only in a cycle with `disp_valid`, `disp_ready` high and `stall_in` low; otherwise `disp_pc` and `disp_instr` hold.
- R6: While dispatch is stalled, fetching continues until the queue plus in-flight requests reach `DEPTH`.
- R7: While the memory is slow or refuses requests, dispatch keeps emptying the queue.
- R8: A word whose bits [31:26] equal 6'b000010 is an unconditional jump with target = its PC + 4 × sign-extended bits [25:0]. The request address becomes that target in the cycle after the jump's response arrives, and the request tag changes.
- R9: The jump word itself is dispatched, with its own PC, in program order.
- R10: Every response is returned with the tag of its request, in request order. A response whose tag differs from the current epoch is dropped and never dispatched.
- R11: A kept response arriving at an empty queue is visible on the dispatch outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Fetch request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Fetch byte address |
| mem_req_tag | output | EPOCH_W | Epoch tag of the request |
| mem_rsp_valid | input | 1 | Response word present, always accepted |
| mem_rsp_data | input | 32 | Returned instruction word |
| mem_rsp_tag | input | EPOCH_W | Tag echoed from the request |
| disp_valid | output | 1 | Queue head is valid |
| disp_ready | input | 1 | Dispatch stage can take an instruction |
| disp_pc | output | AW | PC of the queue head |
| disp_instr | output | 32 | Instruction at the queue head |
| stall_in | input | 1 | Stall from later stages, blocks dispatch |

## Verification
The hardest case to reach from the ports is a jump response that arrives while stale sequential requests are still outstanding. When that happens, old-tag words have to be discarded while the credit count still includes them. The bench's memory model gives each request a latency and answers strictly in order. The program loops through two jumps, one forward and one backward. Its phases mix long latencies, refused requests and a stalled dispatch, so several words are always in flight when a jump returns. A mid-run reset also clears a full queue while requests are still outstanding.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam logic [5:0] JUMP_OPC = 6'b000010;

  function automatic logic is_jump(input logic [31:0] word);
    return word[31:26] == JUMP_OPC;
  endfunction
endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = slots[rd_ptr];

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(DEPTH)));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int             AW       = 32,
  parameter int             DEPTH    = 4,
  parameter int             CW       = 3,
  parameter int             EPOCH_W  = 2,
  parameter logic [AW-1:0]  RESET_PC = 'h100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      q_count,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  output logic [EPOCH_W-1:0] mem_req_tag,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  input  logic [EPOCH_W-1:0] mem_rsp_tag,
  output logic               keep,
  output logic [AW-1:0]      keep_pc
);
  logic [AW-1:0]      fetch_pc, rsp_pc, target;
  logic [EPOCH_W-1:0] epoch;
  logic [CW-1:0]      inflight;
  logic [CW:0]        used;
  logic               req_fire, redirect;
  logic signed [27:0] boff;

  assign used          = {1'b0, q_count} + {1'b0, inflight};
  assign mem_req_valid = used < (CW+1)'(DEPTH);
  assign mem_req_addr  = fetch_pc;
  assign mem_req_tag   = epoch;
  assign req_fire      = mem_req_valid && mem_req_ready;

  assign keep     = mem_rsp_valid && (mem_rsp_tag == epoch);
  assign keep_pc  = rsp_pc;
  assign redirect = keep && is_jump(mem_rsp_data);
  assign boff     = $signed({mem_rsp_data[25:0], 2'b00});
  assign target   = rsp_pc + AW'(boff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= RESET_PC;
      rsp_pc   <= RESET_PC;
      epoch    <= '0;
      inflight <= '0;
    end else begin
      if (redirect)      fetch_pc <= target;
      else if (req_fire) fetch_pc <= fetch_pc + AW'(4);

      if (redirect)  rsp_pc <= target;
      else if (keep) rsp_pc <= rsp_pc + AW'(4);

      if (redirect) epoch <= epoch + 1'b1;

      case ({req_fire, mem_rsp_valid})
        2'b10:   inflight <= inflight + 1'b1;
        2'b01:   inflight <= inflight - 1'b1;
        default: inflight <= inflight;
      endcase
    end
  end

  // R3
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (CW+1)'(DEPTH));

  // R10
  rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (inflight != '0));

  // R8
  redirect_retag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (mem_req_tag != $past(mem_req_tag)));
endmodule

// File: rtl/prefetch_dispatch_queue.sv
module prefetch_dispatch_queue #(
  parameter int             AW       = 32,
  parameter int             DEPTH    = 4,
  parameter int             EPOCH_W  = 2,
  parameter logic [AW-1:0]  RESET_PC = 'h100
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  output logic [EPOCH_W-1:0] mem_req_tag,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  input  logic [EPOCH_W-1:0] mem_rsp_tag,
  output logic               disp_valid,
  input  logic               disp_ready,
  output logic [AW-1:0]      disp_pc,
  output logic [31:0]        disp_instr,
  input  logic               stall_in
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = AW + 32;

  logic [CW-1:0] q_count;
  logic          keep, pop;
  logic [AW-1:0] keep_pc;
  logic [EW-1:0] head;

  pfq_fetch #(
    .AW(AW), .DEPTH(DEPTH), .CW(CW), .EPOCH_W(EPOCH_W), .RESET_PC(RESET_PC)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .q_count(q_count),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_tag(mem_rsp_tag), .keep(keep), .keep_pc(keep_pc)
  );

  pfq_fifo #(.W(EW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(keep), .push_data({keep_pc, mem_rsp_data}),
    .pop(pop), .head(head), .count(q_count)
  );

  assign disp_valid = q_count != '0;
  assign pop        = disp_valid && disp_ready && !stall_in;
  assign disp_pc    = head[EW-1:32];
  assign disp_instr = head[31:0];

  // R5
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !pop) |=> (disp_valid && $stable(disp_pc) && $stable(disp_instr)));

  // R11
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> disp_valid);
endmodule

// File: tb/prefetch_dispatch_queue_test.sv
module prefetch_dispatch_queue_test;
  localparam int          DEPTH    = 4;
  localparam logic [31:0] RESET_PC = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_tag;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic [1:0]  mem_rsp_tag;
  logic        disp_valid, disp_ready, stall_in;
  logic [31:0] disp_pc, disp_instr;

  always #5 clk = ~clk;

  prefetch_dispatch_queue #(.AW(32), .DEPTH(DEPTH), .EPOCH_W(2), .RESET_PC(RESET_PC)) uut (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_tag(mem_rsp_tag), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_pc(disp_pc), .disp_instr(disp_instr), .stall_in(stall_in)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lat = 1;

  logic [31:0] mq_addr [$];
  logic [1:0]  mq_tag  [$];
  int          mq_due  [$];

  int          occ, outstanding;
  logic [31:0] exp_disp_pc, keep_pc, req_exp, raddr;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [31:0] instr_at(input logic [31:0] a);
    case (a)
      32'h108: return {6'b100010, 26'h10};
      32'h110: return {6'b000010, 26'd16};
      32'h154: return {6'b000011, 26'h3FFFFFF};
      32'h15C: return {6'b000010, 26'h3FFFFE9};
      default: return {6'h23, a[25:0]};
    endcase
  endfunction

  function automatic logic [31:0] next_pc(input logic [31:0] a);
    logic [31:0] w;
    w = instr_at(a);
    if (w[31:26] == 6'b000010) return a + {{4{w[25]}}, w[25:0], 2'b00};
    return a + 32'd4;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    mq_addr.delete(); mq_tag.delete(); mq_due.delete();
    occ = 0; outstanding = 0;
    exp_disp_pc = RESET_PC; keep_pc = RESET_PC; req_exp = RESET_PC;
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst_n = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_data = '0; mem_rsp_tag = '0; disp_ready = 1'b0; stall_in = 1'b0;
    model_reset();
    repeat (n) @(negedge clk);
    #1;
    chk(disp_valid == 1'b0, "R1 disp_valid in reset", 32'(disp_valid), 32'd0);
    chk(mem_req_addr == RESET_PC, "R1 reset address", mem_req_addr, RESET_PC);
    rst_n = 1'b1;
  endtask

  task automatic step(input bit rq_rdy, input bit d_rdy, input bit stl);
    bit got_rsp, req_fire, pop;
    @(negedge clk);
    cyc++;
    mem_req_ready = rq_rdy; disp_ready = d_rdy; stall_in = stl;
    got_rsp = 1'b0;
    if (mq_addr.size() > 0 && mq_due[0] <= cyc) begin
      got_rsp = 1'b1;
      raddr = mq_addr.pop_front();
      mem_rsp_tag = mq_tag.pop_front();
      void'(mq_due.pop_front());
      mem_rsp_data = instr_at(raddr);
    end
    mem_rsp_valid = got_rsp;
    #1;
    // R4 R7 R11: valid tracks the model's occupancy
    chk(disp_valid == (occ > 0), "R4/R7/R11 disp_valid", 32'(disp_valid), 32'(occ > 0));
    if (disp_valid && occ > 0) begin
      // R4 R9 R10: program order, jump included, stale words absent
      chk(disp_pc == exp_disp_pc, "R4/R9/R10 disp_pc", disp_pc, exp_disp_pc);
      chk(disp_instr == instr_at(exp_disp_pc), "R9 disp_instr", disp_instr, instr_at(exp_disp_pc));
    end
    // R3 R6: credit rule
    chk(mem_req_valid == (occ + outstanding < DEPTH), "R3/R6 mem_req_valid",
        32'(mem_req_valid), 32'(occ + outstanding < DEPTH));
    // R2 R8: sequential address or jump target
    if (mem_req_valid)
      chk(mem_req_addr == req_exp, "R2/R8 mem_req_addr", mem_req_addr, req_exp);
    req_fire = mem_req_valid && rq_rdy;
    pop      = disp_valid && d_rdy && !stl;
    if (req_fire) begin
      mq_addr.push_back(mem_req_addr);
      mq_tag.push_back(mem_req_tag);
      mq_due.push_back(cyc + lat);
      outstanding++;
      req_exp = req_exp + 32'd4;
    end
    if (got_rsp) begin
      outstanding--;
      if (raddr == keep_pc) begin
        occ++;
        if (next_pc(raddr) != raddr + 32'd4) req_exp = next_pc(raddr);
        keep_pc = next_pc(raddr);
      end
    end
    // R5: removal only on valid, ready and no stall
    if (pop) begin
      occ--;
      exp_disp_pc = next_pc(exp_disp_pc);
    end
  endtask

  initial begin
    do_reset(3);
    lat = 1;
    for (int i = 0; i < 200; i++) step(1'b1, 1'b1, 1'b0);
    lat = 2;
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b1);
    @(posedge clk); #1;
    chk(mem_req_valid == 1'b0, "R6 fetch stops when full", 32'(mem_req_valid), 32'd0);
    chk(disp_valid == 1'b1, "R6 queue holds entries under stall", 32'(disp_valid), 32'd1);
    lat = 9;
    for (int i = 0; i < 150; i++) step((cyc % 3) != 0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1);
    do_reset(2);
    for (int i = 0; i < 800; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lat = 1 + int'(lf[2:0] % 3'd6);
      step(lf[4] | lf[5], lf[7] | lf[8], lf[9] & lf[11]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule